// File: doc/BRIEF.md
# Interrupt Redirection Channel

This block is a single input channel of an I/O interrupt controller. It stores a 64-bit redirection entry that software reaches as two 32-bit halves through a small write/read port with a half-select line. The entry sets the vector, the destination addressing mode, the destination identifier, the extended destination identifier and a mask. It also holds a flush-disable control that has no effect on behaviour, and shows a read-only delivery-type flag that always reads 1.

The interrupt pin passes through an optional synchronizer, and the channel then detects rising edges on it. An unmasked rising edge sets the delivery-status flag. The channel latches a message request (vector, mode, destination and a formed message address) and holds it on its outputs until the bus unit returns an acknowledge. While the request is pending, further edges on the pin are not recognized. After the acknowledge, only a fresh rising edge starts a new request.

The message address is a fixed base, then the effective destination in bits 19:12, then the extended destination identifier in bits 11:4, with zeros below. In physical mode the effective destination is only the low 4 bits of the destination field, zero-extended. In logical mode it is the whole 8-bit field.

Top module: `irq_redir_channel`

## Requirements
- R1: After reset msg_req is 0, the low half reads 0x0001_8000 (mask bit 16 set, delivery-type bit 15 set) and the high half reads 0.
- R2: Low-half layout: bits 7:0 vector, bit 11 destination mode (0 physical, 1 logical), bit 14 flush-disable and bit 16 mask are read/write. Bit 12 is the read-only delivery-status flag. All other low bits read 0.
- R3: High-half layout: bits 31:24 (entry bits 63:56) destination and bits 23:16 (entry bits 55:48) extended destination ID are read/write. All other high bits read 0.
- R4: Bit 15 of the low half always reads 1, whatever is written to it.
- R5: With the mask clear, a rising edge on irq_pin sets msg_req and status bit 12 exactly SYNC_STAGES+1 clock edges after the pin rises.
- R6: While msg_req is 1 and msg_ack is 0, msg_req stays 1 and msg_vector, msg_logical, msg_dest and msg_addr hold their captured values, even if software rewrites the entry.
- R7: msg_dest is the full 8-bit destination field in logical mode. In physical mode it is {4'b0, field[3:0]}.
- R8: msg_addr equals {12'hFEE, msg_dest, extended ID, 4'b0000}, so the extended ID lands in address bits 11:4.
- R9: An acknowledge sampled while a request is pending clears msg_req and status bit 12 at that clock edge.
- R10: Rising edges that occur while a request is pending are ignored: after the acknowledge, no new request appears until a fresh rising edge.
- R11: A rising edge while the mask is set is discarded, and clearing the mask while the pin stays high raises no request.
- R12: The flush-disable bit has no effect on capture, fields or timing.
- R13: An acknowledge while no request is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the selected half |
| reg_half | input | 1 | Half select: 0 low (entry bits 31:0), 1 high (entry bits 63:32) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected half |
| irq_pin | input | 1 | Interrupt input pin |
| msg_ack | input | 1 | Message-sent acknowledge from the bus unit |
| msg_req | output | 1 | Message request pending |
| msg_vector | output | 8 | Captured vector |
| msg_logical | output | 1 | Captured destination mode |
| msg_dest | output | 8 | Captured effective destination |
| msg_addr | output | 32 | Formed message address |

## Verification
The assertions assume that msg_ack arrives only as a single-cycle answer and that irq_pin is a clean level once synchronized. They also assume that software may rewrite the entry at any time, including while a request is pending. The stimulus drives the pin and the acknowledge only at falling clock edges and pulses the acknowledge for exactly one cycle per request. Spurious acknowledges are sent only while the channel is idle, so that R13 is covered. Entry rewrites during a pending request are issued on purpose, to confirm that the captured fields do not move.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

   typedef enum logic [0:0] {
      CH_IDLE = 1'b0,
      CH_PEND = 1'b1
   } chan_state_e;

   localparam int unsigned LO_MODE_BIT   = 11;
   localparam int unsigned LO_STATUS_BIT = 12;
   localparam int unsigned LO_FLUSH_BIT  = 14;
   localparam int unsigned LO_DTYPE_BIT  = 15;
   localparam int unsigned LO_MASK_BIT   = 16;

endpackage

// File: rtl/irq_redir_edge.sv
module irq_redir_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o
);

   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign level_o = pin_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
         end
         assign level_o = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_o;
   end

   assign rise_o = level_o & ~prev_q;

endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
   import irq_redir_pkg::*;
#(
   parameter int unsigned HALF_W = 32,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned DEST_W = 8,
   parameter int unsigned EDID_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              half_i,
   input  logic [HALF_W-1:0] wdata_i,
   input  logic              status_i,
   output logic [HALF_W-1:0] rdata_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              logical_o,
   output logic              mask_o,
   output logic [DEST_W-1:0] dest_o,
   output logic [EDID_W-1:0] edid_o
);

   localparam int unsigned DEST_LSB = HALF_W - DEST_W;
   localparam int unsigned EDID_LSB = DEST_LSB - EDID_W;

   generate
      if (VEC_W > LO_MODE_BIT) begin : g_bad_vec
         $error("VEC_W overlaps the mode bit");
      end
      if (DEST_W + EDID_W > HALF_W) begin : g_bad_hi
         $error("destination fields exceed the high half");
      end
      if (HALF_W <= LO_MASK_BIT) begin : g_bad_lo
         $error("HALF_W too small for the low-half layout");
      end
   endgenerate

   logic [VEC_W-1:0]  vec_q;
   logic              mode_q;
   logic              flush_q;
   logic              mask_q;
   logic [DEST_W-1:0] dest_q;
   logic [EDID_W-1:0] edid_q;
   logic [HALF_W-1:0] lo_view;
   logic [HALF_W-1:0] hi_view;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q   <= '0;
         mode_q  <= 1'b0;
         flush_q <= 1'b0;
         mask_q  <= 1'b1;
         dest_q  <= '0;
         edid_q  <= '0;
      end else if (wr_en_i) begin
         if (!half_i) begin
            vec_q   <= wdata_i[VEC_W-1:0];
            mode_q  <= wdata_i[LO_MODE_BIT];
            flush_q <= wdata_i[LO_FLUSH_BIT];
            mask_q  <= wdata_i[LO_MASK_BIT];
         end else begin
            dest_q  <= wdata_i[DEST_LSB +: DEST_W];
            edid_q  <= wdata_i[EDID_LSB +: EDID_W];
         end
      end
   end

   always_comb begin
      lo_view                = '0;
      lo_view[VEC_W-1:0]     = vec_q;
      lo_view[LO_MODE_BIT]   = mode_q;
      lo_view[LO_STATUS_BIT] = status_i;
      lo_view[LO_FLUSH_BIT]  = flush_q;
      lo_view[LO_DTYPE_BIT]  = 1'b1;
      lo_view[LO_MASK_BIT]   = mask_q;
      hi_view                = '0;
      hi_view[DEST_LSB +: DEST_W] = dest_q;
      hi_view[EDID_LSB +: EDID_W] = edid_q;
   end

   assign rdata_o   = half_i ? hi_view : lo_view;
   assign vec_o     = vec_q;
   assign logical_o = mode_q;
   assign mask_o    = mask_q;
   assign dest_o    = dest_q;
   assign edid_o    = edid_q;

   logic unused_wbits;
   assign unused_wbits = ^wdata_i;

   a_r4_dtype_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
      !half_i |-> rdata_o[LO_DTYPE_BIT]);

endmodule

// File: rtl/irq_redir_deliver.sv
module irq_redir_deliver
   import irq_redir_pkg::*;
#(
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned DEST_W = 8,
   parameter int unsigned PHYS_W = 4,
   parameter int unsigned EDID_W = 8,
   parameter int unsigned BASE_W = 12,
   parameter logic [BASE_W-1:0] ADDR_BASE = 12'hFEE,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              mask_i,
   input  logic [VEC_W-1:0]  vec_i,
   input  logic              logical_i,
   input  logic [DEST_W-1:0] dest_i,
   input  logic [EDID_W-1:0] edid_i,
   input  logic              ack_i,
   output logic              pending_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              logical_o,
   output logic [DEST_W-1:0] dest_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int unsigned LOW_PAD = ADDR_W - BASE_W - DEST_W - EDID_W;

   generate
      if (BASE_W + DEST_W + EDID_W + 4 != ADDR_W) begin : g_bad_addr
         $error("address fields must leave exactly 4 low bits below the extended ID");
      end
      if (PHYS_W > DEST_W) begin : g_bad_phys
         $error("PHYS_W must not exceed DEST_W");
      end
   endgenerate

   chan_state_e       st_q;
   logic [VEC_W-1:0]  vec_q;
   logic              log_q;
   logic [DEST_W-1:0] dest_q;
   logic [EDID_W-1:0] edid_q;
   logic [DEST_W-1:0] dest_eff;
   logic              accept;

   generate
      if (PHYS_W < DEST_W) begin : g_narrow
         assign dest_eff = logical_i ? dest_i
                                     : {{(DEST_W-PHYS_W){1'b0}}, dest_i[PHYS_W-1:0]};
      end else begin : g_full
         assign dest_eff = dest_i;
      end
   endgenerate

   assign accept = (st_q == CH_IDLE) && rise_i && !mask_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= CH_IDLE;
         vec_q  <= '0;
         log_q  <= 1'b0;
         dest_q <= '0;
         edid_q <= '0;
      end else begin
         case (st_q)
            CH_IDLE: begin
               if (accept) begin
                  st_q   <= CH_PEND;
                  vec_q  <= vec_i;
                  log_q  <= logical_i;
                  dest_q <= dest_eff;
                  edid_q <= edid_i;
               end
            end
            CH_PEND: begin
               if (ack_i) st_q <= CH_IDLE;
            end
            default: st_q <= CH_IDLE;
         endcase
      end
   end

   assign pending_o = (st_q == CH_PEND);
   assign vec_o     = vec_q;
   assign logical_o = log_q;
   assign dest_o    = dest_q;
   assign addr_o    = {ADDR_BASE, dest_q, edid_q, {LOW_PAD{1'b0}}};

   a_r6_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
      pending_o && !ack_i |=> pending_o && $stable(vec_o) && $stable(dest_o)
                              && $stable(logical_o) && $stable(addr_o));

   a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      pending_o && ack_i |=> !pending_o);

   a_r11_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !pending_o && mask_i |=> !pending_o);

   a_r13_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !pending_o && !rise_i && ack_i |=> !pending_o);

endmodule

// File: rtl/irq_redir_channel.sv
module irq_redir_channel #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HALF_W      = 32,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned DEST_W      = 8,
   parameter int unsigned PHYS_W      = 4,
   parameter int unsigned EDID_W      = 8,
   parameter int unsigned BASE_W      = 12,
   parameter logic [BASE_W-1:0] ADDR_BASE = 12'hFEE,
   parameter int unsigned ADDR_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_half,
   input  logic [HALF_W-1:0] reg_wdata,
   output logic [HALF_W-1:0] reg_rdata,
   input  logic              irq_pin,
   input  logic              msg_ack,
   output logic              msg_req,
   output logic [VEC_W-1:0]  msg_vector,
   output logic              msg_logical,
   output logic [DEST_W-1:0] msg_dest,
   output logic [ADDR_W-1:0] msg_addr
);

   logic              level_w;
   logic              rise_w;
   logic [VEC_W-1:0]  vec_w;
   logic              logical_w;
   logic              mask_w;
   logic [DEST_W-1:0] dest_w;
   logic [EDID_W-1:0] edid_w;

   irq_redir_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (irq_pin),
      .level_o (level_w),
      .rise_o  (rise_w)
   );

   irq_redir_regs #(
      .HALF_W (HALF_W),
      .VEC_W  (VEC_W),
      .DEST_W (DEST_W),
      .EDID_W (EDID_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (reg_wr),
      .half_i    (reg_half),
      .wdata_i   (reg_wdata),
      .status_i  (msg_req),
      .rdata_o   (reg_rdata),
      .vec_o     (vec_w),
      .logical_o (logical_w),
      .mask_o    (mask_w),
      .dest_o    (dest_w),
      .edid_o    (edid_w)
   );

   irq_redir_deliver #(
      .VEC_W     (VEC_W),
      .DEST_W    (DEST_W),
      .PHYS_W    (PHYS_W),
      .EDID_W    (EDID_W),
      .BASE_W    (BASE_W),
      .ADDR_BASE (ADDR_BASE),
      .ADDR_W    (ADDR_W)
   ) u_deliver (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (rise_w),
      .mask_i    (mask_w),
      .vec_i     (vec_w),
      .logical_i (logical_w),
      .dest_i    (dest_w),
      .edid_i    (edid_w),
      .ack_i     (msg_ack),
      .pending_o (msg_req),
      .vec_o     (msg_vector),
      .logical_o (msg_logical),
      .dest_o    (msg_dest),
      .addr_o    (msg_addr)
   );

   a_r5_rise_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_req) |-> $past(level_w));

   a_r7_phys_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      msg_req && !msg_logical |-> (msg_dest >> PHYS_W) == '0);

   a_r8_addr_dest: assert property (@(posedge clk) disable iff (!rst_n)
      msg_req |-> msg_addr[ADDR_W-BASE_W-1 -: DEST_W] == msg_dest);

endmodule

// File: tb/irq_redir_channel_test.sv
`timescale 1ns/1ps
module irq_redir_channel_test;

   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_half = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_pin = 1'b0;
   logic        msg_ack = 1'b0;
   logic        msg_req;
   logic [7:0]  msg_vector;
   logic        msg_logical;
   logic [7:0]  msg_dest;
   logic [31:0] msg_addr;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   irq_redir_channel uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_half(reg_half),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin),
      .msg_ack(msg_ack), .msg_req(msg_req), .msg_vector(msg_vector),
      .msg_logical(msg_logical), .msg_dest(msg_dest), .msg_addr(msg_addr)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: act 0x%08h exp 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic half, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_half = half; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic half, output logic [31:0] d);
      @(negedge clk);
      reg_half = half;
      #1 d = reg_rdata;
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ack_pulse();
      @(negedge clk);
      msg_ack = 1'b1;
      @(negedge clk);
      msg_ack = 1'b0;
   endtask

   initial begin
      logic [31:0] v;
      logic [7:0]  vec, dst, ed, eff;
      logic [31:0] lo_w, hi_w;

      cycles(3);
      rst_n = 1'b1;
      // R1 reset state
      rd(1'b0, v); chk("R1 low half", v, 32'h0001_8000);
      rd(1'b1, v); chk("R1 high half", v, 32'h0);
      chk("R1 msg_req", {31'b0, msg_req}, 32'h0);

      // R2 R3 R4 readback masks
      wr(1'b0, 32'hFFFF_FFFF); rd(1'b0, v); chk("R2 low all ones", v, 32'h0001_C8FF);
      wr(1'b0, 32'h0000_0000); rd(1'b0, v); chk("R4 dtype stays one", v, 32'h0000_8000);
      wr(1'b0, 32'hA5A5_5A5A); rd(1'b0, v);
      chk("R2 low pattern", v, (32'hA5A5_5A5A & 32'h0001_48FF) | 32'h8000);
      wr(1'b1, 32'hFFFF_FFFF); rd(1'b1, v); chk("R3 high all ones", v, 32'hFFFF_0000);
      wr(1'b1, 32'h1234_5678); rd(1'b1, v); chk("R3 high pattern", v, 32'h1234_0000);

      // R13 ack while idle
      wr(1'b0, 32'h0);
      ack_pulse(); cycles(1);
      chk("R13 idle ack", {31'b0, msg_req}, 32'h0);

      // sweep over mode and destination
      for (int m = 0; m < 2; m++) begin
         for (int d = 0; d < 256; d++) begin
            vec = 8'(d) ^ 8'h5A;
            dst = 8'(d);
            ed  = ~8'(d);
            eff = (m == 1) ? dst : (dst & 8'h0F);
            lo_w = {24'b0, vec} | (32'(m) << 11) | (32'(d & 1) << 14); // R12 flush bit varies
            hi_w = {dst, ed, 16'h0};
            wr(1'b1, hi_w);
            wr(1'b0, lo_w);
            @(negedge clk); irq_pin = 1'b1;
            cycles(LAT - 1);
            chk("R5 not yet", {31'b0, msg_req}, 32'h0);
            cycles(1);
            chk("R5 msg_req", {31'b0, msg_req}, 32'h1);
            rd(1'b0, v); chk("R5 status bit", {31'b0, v[12]}, 32'h1);
            chk("R6 vector", {24'b0, msg_vector}, {24'b0, vec});
            chk("R7 mode", {31'b0, msg_logical}, 32'(m));
            chk("R7 dest", {24'b0, msg_dest}, {24'b0, eff});
            chk("R8 addr", msg_addr, (32'hFEE << 20) | (32'(eff) << 12) | (32'(ed) << 4));
            if (d % 8 == 0) begin
               // R6 rewrites while pending; R10 extra edge while pending
               wr(1'b0, lo_w ^ 32'h0000_08FF);
               wr(1'b1, ~hi_w);
               irq_pin = 1'b0; cycles(2); irq_pin = 1'b1; cycles(LAT + 1);
               chk("R6 vector held", {24'b0, msg_vector}, {24'b0, vec});
               chk("R6 addr held", msg_addr, (32'hFEE << 20) | (32'(eff) << 12) | (32'(ed) << 4));
               chk("R6 req held", {31'b0, msg_req}, 32'h1);
            end
            ack_pulse();
            chk("R9 req cleared", {31'b0, msg_req}, 32'h0);
            rd(1'b0, v); chk("R9 status cleared", {31'b0, v[12]}, 32'h0);
            if (d % 8 == 0) begin
               cycles(LAT + 2);
               chk("R10 no recapture", {31'b0, msg_req}, 32'h0);
            end
            @(negedge clk); irq_pin = 1'b0;
            cycles(LAT + 1);
         end
      end

      // R11 masked edge discarded, unmask with pin high gives nothing
      wr(1'b0, 32'h0001_0033);
      @(negedge clk); irq_pin = 1'b1;
      cycles(LAT + 2);
      chk("R11 masked edge", {31'b0, msg_req}, 32'h0);
      wr(1'b0, 32'h0000_0033);
      cycles(LAT + 2);
      chk("R11 unmask with pin high", {31'b0, msg_req}, 32'h0);
      @(negedge clk); irq_pin = 1'b0;
      cycles(LAT + 1);
      @(negedge clk); irq_pin = 1'b1;
      cycles(LAT);
      chk("R11 fresh edge after unmask", {31'b0, msg_req}, 32'h1);
      chk("R11 vector", {24'b0, msg_vector}, 32'h33);
      ack_pulse();
      chk("R9 final clear", {31'b0, msg_req}, 32'h0);
      irq_pin = 1'b0;
      cycles(4);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule